// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block lets a handful of pins serve two purposes. When the supply becomes valid, every shared pin driver stays in high impedance for a fixed sampling window. During that window the external pull-up or pull-down resistor on each pin sets its level. When the window closes, the level on every pin is stored in its own configuration bit. A ready flag is raised at the same time. After that, each pin becomes a clock output driven from its own internal clock source.

The sampling window is set by two parameters: the reference clock frequency and the window length in microseconds. The power-good input passes through a two-stage synchronizer before it starts the window timer. Each pin's output enable is retimed to the falling edge of that pin's clock. The pin therefore starts by driving low, and its first visible pulse has full width.

A drop of power-good is treated as a power cycle. It clears the stored bits, drops the ready flag, returns the pins to high impedance and restarts the full window. Nothing else can change the stored bits.

Top module: `strap_boot_ctrl`

## Requirements
- R1: While `por_n` is low, `pad_oe`, `strap_q` and `straps_valid` are all 0.
- R2: The window lasts WIN = (REF_CLK_HZ / 1,000,000) × WINDOW_US reference cycles. Counting the first rising edge of `clk_ref` that samples `pwr_good` high as edge 1, `straps_valid` goes high right after edge WIN+3: two synchronizer stages, one start cycle, then WIN counting cycles. It is still low after edge WIN+2.
- R3: Whenever `straps_valid` is 0, every bit of `pad_oe` is 0.
- R4: Bit i of `strap_q` holds the level of `pad_in[i]` at the rising edge that ends the window: a low level stores 0 and a high level stores 1.
- R5: `straps_valid` rises in the same cycle that `strap_q` takes the sampled levels.
- R6: While `straps_valid` stays high, `strap_q` does not change, whatever the levels on `pad_in`.
- R7: If `pwr_good` is low for three consecutive rising edges of `clk_ref`, then right after the third one `straps_valid`, `strap_q` and `pad_oe` are 0. The next rise of `pwr_good` restarts the full window, and this also applies to a drop in the middle of a window.
- R8: Each `pad_oe[i]` rises only while `clk_src[i]` is low.
- R9: Once `straps_valid` is high, each `pad_oe[i]` goes high within two falling edges of `clk_src[i]`. From then on, `pad_out[i]` follows `clk_src[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock for the synchronizer, timer and capture |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_good | input | 1 | Supply-valid indication, asynchronous |
| clk_src | input | NUM_PINS | Internal clock to be driven on each shared pin |
| pad_in | input | NUM_PINS | Level observed at each shared pin |
| pad_oe | output | NUM_PINS | Output driver enable for each shared pin |
| pad_out | output | NUM_PINS | Output driver data for each shared pin |
| strap_q | output | NUM_PINS | Stored configuration bits |
| straps_valid | output | 1 | High while the stored bits are valid |

## Verification
On every reference cycle, the assertions check that the drivers stay off whenever the ready flag is low and that the stored bits hold steady while the flag stays high. They also check that a sustained loss of power-good clears everything. A cycle counter in the checker confirms that the flag rises exactly WIN+3 edges after power-good comes up. The bench scenarios cover the rest: the value captured for every strap pattern, the clean first pulse on each pin clock, and that the outputs follow their source clocks. They also show that a power loss in the middle of the window restarts the whole count.

// File: rtl/strap_boot_pkg.sv
package strap_boot_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_RUN    = 2'd2
  } boot_state_e;

  function automatic int unsigned win_cycles(input int unsigned ref_hz,
                                             input int unsigned win_us);
    return (ref_hz / 1_000_000) * win_us;
  endfunction
endpackage

// File: rtl/strap_pg_sync.sv
module strap_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign q = sync_q[STAGES-1];
endmodule

// File: rtl/strap_window_fsm.sv
module strap_window_fsm
  import strap_boot_pkg::*;
#(
  parameter int NUM_PINS   = 5,
  parameter int WIN_CYCLES = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pg_ok,
  input  logic [NUM_PINS-1:0] pad_lvl,
  output logic [NUM_PINS-1:0] strap_q,
  output logic                valid
);
  localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  boot_state_e         state_q, state_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                cap_en;
  logic [NUM_PINS-1:0] strap_d;
  logic                valid_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    if (!pg_ok) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_SAMPLE;
          cnt_d   = '0;
        end
        ST_SAMPLE: begin
          if (cnt_q == LAST) begin
            state_d = ST_RUN;
            cap_en  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_comb begin
    strap_d = strap_q;
    if (!pg_ok)      strap_d = '0;
    else if (cap_en) strap_d = pad_lvl;
    valid_d = (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      strap_q <= '0;
      valid   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      strap_q <= strap_d;
      valid   <= valid_d;
    end
  end
endmodule

// File: rtl/strap_oe_align.sv
module strap_oe_align (
  input  logic clk_src,
  input  logic rst_n,
  input  logic run,
  output logic oe
);
  logic       arst_n;
  logic [1:0] en_q;
  logic [1:0] en_d;

  assign arst_n = rst_n & run;

  always_comb begin
    en_d = {en_q[0], 1'b1};
  end

  always_ff @(negedge clk_src or negedge arst_n) begin
    if (!arst_n) en_q <= 2'b00;
    else         en_q <= en_d;
  end

  assign oe = en_q[1];
endmodule

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl
  import strap_boot_pkg::*;
#(
  parameter int NUM_PINS   = 5,
  parameter int REF_CLK_HZ = 50_000_000,
  parameter int WINDOW_US  = 2000
) (
  input  logic                clk_ref,
  input  logic                por_n,
  input  logic                pwr_good,
  input  logic [NUM_PINS-1:0] clk_src,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] strap_q,
  output logic                straps_valid
);
  localparam int WIN_CYCLES = int'(win_cycles(REF_CLK_HZ, WINDOW_US));

  logic pg_ok;

  strap_pg_sync #(.STAGES(2)) u_pg_sync (
    .clk   (clk_ref),
    .rst_n (por_n),
    .d     (pwr_good),
    .q     (pg_ok)
  );

  strap_window_fsm #(
    .NUM_PINS   (NUM_PINS),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_window (
    .clk     (clk_ref),
    .rst_n   (por_n),
    .pg_ok   (pg_ok),
    .pad_lvl (pad_in),
    .strap_q (strap_q),
    .valid   (straps_valid)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    strap_oe_align u_align (
      .clk_src (clk_src[i]),
      .rst_n   (por_n),
      .run     (straps_valid),
      .oe      (pad_oe[i])
    );
    assign pad_out[i] = clk_src[i] & pad_oe[i];
  end
endmodule

// File: rtl/strap_boot_ctrl_chk.sv
module strap_boot_ctrl_chk
  import strap_boot_pkg::*;
#(
  parameter int NUM_PINS   = 5,
  parameter int REF_CLK_HZ = 50_000_000,
  parameter int WINDOW_US  = 2000
) (
  input logic                clk_ref,
  input logic                por_n,
  input logic                pwr_good,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] strap_q,
  input logic                straps_valid
);
  localparam int WIN    = int'(win_cycles(REF_CLK_HZ, WINDOW_US));
  localparam int PW     = $clog2(WIN + 8) + 1;
  localparam logic [PW-1:0] RISE_AT = PW'(WIN + 3);
  localparam logic [PW-1:0] SAT     = PW'(WIN + 4);

  logic [PW-1:0] pg_run_q;

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n)             pg_run_q <= '0;
    else if (!pwr_good)     pg_run_q <= '0;
    else if (pg_run_q != SAT) pg_run_q <= pg_run_q + 1'b1;
  end

  // R2: ready rises exactly WIN+3 edges after power-good is first seen high
  assert_window_len_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(straps_valid) |-> (pg_run_q == RISE_AT));

  // R3: drivers off whenever ready is low
  assert_hiz_window_R3: assert property (@(posedge clk_ref) disable iff (!por_n)
    !straps_valid |-> (pad_oe == '0));

  // R6: stored bits hold while ready stays high
  assert_straps_hold_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    (straps_valid && $past(straps_valid)) |-> $stable(strap_q));

  // R7: sustained power loss clears everything
  assert_power_loss_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    (!pwr_good && !$past(pwr_good) && !$past(pwr_good, 2) && !$past(pwr_good, 3))
      |-> (!straps_valid && strap_q == '0 && pad_oe == '0));
endmodule

bind strap_boot_ctrl strap_boot_ctrl_chk #(
  .NUM_PINS   (NUM_PINS),
  .REF_CLK_HZ (REF_CLK_HZ),
  .WINDOW_US  (WINDOW_US)
) u_chk (
  .clk_ref      (clk_ref),
  .por_n        (por_n),
  .pwr_good     (pwr_good),
  .pad_oe       (pad_oe),
  .strap_q      (strap_q),
  .straps_valid (straps_valid)
);

// File: tb/test_strap_boot_ctrl.sv
`timescale 1ns/1ps
module test_strap_boot_ctrl;
  localparam int N   = 5;
  localparam int HZ  = 50_000_000;
  localparam int WUS = 2;
  localparam int TC  = (HZ / 1_000_000) * WUS;

  logic         clk_ref;
  logic         por_n;
  logic         pwr_good;
  logic [N-1:0] clk_src;
  logic [N-1:0] strap_lvl;
  logic [N-1:0] pad_in;
  logic [N-1:0] pad_oe;
  logic [N-1:0] pad_out;
  logic [N-1:0] strap_q;
  logic         straps_valid;

  int n_cmp;
  int n_bad;

  strap_boot_ctrl #(.NUM_PINS(N), .REF_CLK_HZ(HZ), .WINDOW_US(WUS)) i_strap_boot_ctrl (
    .clk_ref      (clk_ref),
    .por_n        (por_n),
    .pwr_good     (pwr_good),
    .clk_src      (clk_src),
    .pad_in       (pad_in),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .strap_q      (strap_q),
    .straps_valid (straps_valid)
  );

  initial clk_ref = 1'b0;
  always #10 clk_ref = ~clk_ref;

  for (genvar i = 0; i < N; i++) begin : g_src
    initial clk_src[i] = 1'b0;
    always #(6 + 3 * i) clk_src[i] = ~clk_src[i];
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : strap_lvl[i];
    // R8: enable may only rise in the low phase of its clock
    always @(posedge pad_oe[i]) chk(clk_src[i] == 1'b0, "R8", 32'(clk_src[i]), 32'd0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drop_power();
    @(negedge clk_ref);
    pwr_good = 1'b0;
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref);
    chk(!straps_valid, "R7", 32'(straps_valid), 32'd0);
    chk(strap_q == '0, "R7", 32'(strap_q), 32'd0);
    chk(pad_oe == '0, "R7", 32'(pad_oe), 32'd0);
    repeat (3) @(negedge clk_ref);
  endtask

  task automatic run_window(input logic [N-1:0] pat);
    int oe_seen;
    oe_seen = 0;
    strap_lvl = pat;
    @(negedge clk_ref);
    pwr_good = 1'b1;
    for (int k = 0; k < TC + 2; k++) begin
      @(posedge clk_ref);
      @(negedge clk_ref);
      if (pad_oe != '0) oe_seen++;
    end
    chk(!straps_valid, "R2", 32'(straps_valid), 32'd0);
    chk(oe_seen == 0, "R3", 32'(oe_seen), 32'd0);
    @(posedge clk_ref);
    @(negedge clk_ref);
    chk(straps_valid, "R2", 32'(straps_valid), 32'd1);
    chk(strap_q == pat, "R4 R5", 32'(strap_q), 32'(pat));
  endtask

  task automatic check_running(input logic [N-1:0] pat);
    repeat (20) @(negedge clk_ref);
    chk(pad_oe == '1, "R9", 32'(pad_oe), 32'h1f);
    for (int i = 0; i < N; i++) begin
      @(posedge clk_src[i]);
      #1;
      chk(pad_out[i] == 1'b1, "R9", 32'(pad_out[i]), 32'd1);
      @(negedge clk_src[i]);
      #1;
      chk(pad_out[i] == 1'b0, "R9", 32'(pad_out[i]), 32'd0);
    end
    strap_lvl = ~pat;
    repeat (5) @(negedge clk_ref);
    chk(strap_q == pat, "R6", 32'(strap_q), 32'(pat));
    chk(straps_valid, "R6", 32'(straps_valid), 32'd1);
  endtask

  task automatic run_all();
    por_n = 1'b0;
    pwr_good = 1'b0;
    strap_lvl = '1;
    repeat (3) @(negedge clk_ref);
    chk(pad_oe == '0, "R1", 32'(pad_oe), 32'd0);
    chk(strap_q == '0, "R1", 32'(strap_q), 32'd0);
    chk(!straps_valid, "R1", 32'(straps_valid), 32'd0);
    por_n = 1'b1;
    repeat (3) @(negedge clk_ref);

    for (int p = 0; p < (1 << N); p++) begin
      run_window(N'(p));
      check_running(N'(p));
      drop_power();
    end

    // R7: power loss in mid-window restarts the full count
    strap_lvl = 5'b01101;
    @(negedge clk_ref);
    pwr_good = 1'b1;
    repeat (TC / 2) @(negedge clk_ref);
    chk(!straps_valid && pad_oe == '0, "R7", 32'(straps_valid), 32'd0);
    drop_power();
    run_window(5'b10010);
    check_running(5'b10010);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_ref);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule